// File: doc/BRIEF.md
# Four-Channel Single-Transfer DMA Controller

This block moves data between up to four peripherals and memory, one transfer per device request. A host sets up each channel through a byte-wide register port: a 16-bit current address, a 16-bit transfer count and an 8-bit page value per channel, plus a mode byte that picks the direction. Because the address and count registers are wider than the port, each is reached through a single 8-bit location. A shared byte-pointer flip-flop steers each access to the low or the high byte.

When an unmasked channel has its request line high, the controller raises a bus request and waits for the bus grant. It then runs exactly one bus cycle. In that cycle it drives a 24-bit memory address made of the page value and the current address, pulses the read or write strobe and acknowledges the device. It then steps the channel's address up and its count down, and gives the bus back. When the count is exhausted the channel flags terminal count, pulses a terminal-count output with its last transfer and masks itself. The host reads and clears the flags through a status register.

Top module: `dmac4_core`

## Requirements
- R1: Each channel's address port (offsets 0..3) and count port (offsets 4..7), with the channel in offset bits 1:0, reaches the low byte when the shared byte pointer is 0 and the high byte when it is 1. Every read or write to any of these eight ports toggles the pointer.
- R2: Any write to the clear-pointer port (offset 14) sets the byte pointer to 0, so the next address or count access lands on the low byte.
- R3: A transfer drives mem_addr = {page, current address}, where the page port of channel c is offset 8+c. The address then increments modulo 2^16, with no carry into the page.
- R4: A count of N-1 gives exactly N transfers. The final transfer (count 0 before it) asserts tc_pulse for that cycle, sets the channel's status flag and masks the channel. After that final transfer the count reads back 0xFFFF.
- R5: A mode write (offset 12) takes its channel from bits 1:0 and its direction from bits 3:2. Direction 01 moves data from the device to memory and pulses mem_wr. Direction 10 moves data from memory to the device and pulses mem_rd. Bits 7:6 are written as 01 (single transfer), the only mode supported.
- R6: A single-mask write (offset 13) selects the channel with bits 1:0. Bit 2 = 1 masks that channel and bit 2 = 0 unmasks it. A masked channel never receives dack while its request is held.
- R7: Reading status (offset 17) returns the terminal-count flags of channels 3..0 in bits 3:0, with bits 7:4 zero. The read clears the flags.
- R8: A write to master clear (offset 15) clears the byte pointer and all status flags and masks all four channels. A write to clear-mask (offset 16) unmasks all four.
- R9: Among channels that are unmasked and requesting, channel 0 wins, then 1, 2 and 3 in that order.
- R10: Each transfer follows the same sequence. hold_req rises and is held until hold_ack is seen. Then, in one cycle, exactly one dack bit is high together with the strobe and the address. After that cycle hold_req is low for at least one cycle.
- R11: After reset all channels are masked, hold_req, dack and the strobes are low, and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 5 | Register offset |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data (combinational, valid while io_rd is high) |
| dreq | input | 4 | Device request per channel |
| dack | output | 4 | Device acknowledge per channel |
| hold_req | output | 1 | Bus request |
| hold_ack | input | 1 | Bus grant |
| mem_addr | output | 24 | Memory address during a transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| tc_pulse | output | 1 | Terminal count, high with the final transfer |

## Verification
The assertions watch the bus protocol on every cycle. They check that dack is one-hot and appears only while the bus is requested and after a grant, that the strobes never overlap and come only with dack, that terminal count rides on a transfer, and that the bus is released after each transfer. The bench scenarios are the only way to show the register-level behaviour. These are the byte-pointer order and its clearing, address wrap inside the page, the exact transfer count, automasking, status clear-on-read, master clear, the mask commands and fixed priority among simultaneous requests.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int CH_W = 2;
  localparam int NCH  = 1 << CH_W;
  localparam int DW   = 8;
  localparam int AW   = 2 * DW;
  localparam int PW   = 8;
  localparam int RW   = 5;

  localparam logic [2:0]    GRP_ADDR   = 3'd0;
  localparam logic [2:0]    GRP_CNT    = 3'd1;
  localparam logic [2:0]    GRP_PAGE   = 3'd2;
  localparam logic [RW-1:0] RA_MODE    = 5'd12;
  localparam logic [RW-1:0] RA_SMASK   = 5'd13;
  localparam logic [RW-1:0] RA_CLRBP   = 5'd14;
  localparam logic [RW-1:0] RA_MCLR    = 5'd15;
  localparam logic [RW-1:0] RA_CLRMASK = 5'd16;
  localparam logic [RW-1:0] RA_STAT    = 5'd17;

  localparam logic [1:0] XT_TOMEM   = 2'b01;
  localparam logic [1:0] XT_FROMMEM = 2'b10;

  typedef enum logic [1:0] {SQ_IDLE, SQ_HOLD, SQ_XFER} sq_state_t;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic          wr_page,
  input  logic          wr_mode,
  input  logic          hi_sel,
  input  logic          set_mask,
  input  logic          clr_mask,
  input  logic          mask_all,
  input  logic          unmask_all,
  input  logic          clr_flag,
  input  logic          step,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cur_cnt,
  output logic [PW-1:0] page,
  output logic [1:0]    xtype,
  output logic          masked,
  output logic          last,
  output logic          flag
);
  logic [AW-1:0] addr_q, addr_d, cnt_q, cnt_d;
  logic [PW-1:0] page_q;
  logic [1:0]    type_q;
  logic          mask_q, mask_d, flag_q, flag_d;
  logic          done;

  assign last = (cnt_q == '0);
  assign done = step && last;

  always_comb begin
    addr_d = addr_q;
    if (step) addr_d = addr_q + 1'b1;
    if (wr_addr) begin
      if (hi_sel) addr_d[AW-1:DW] = wdata;
      else        addr_d[DW-1:0]  = wdata;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = cnt_q - 1'b1;
    if (wr_cnt) begin
      if (hi_sel) cnt_d[AW-1:DW] = wdata;
      else        cnt_d[DW-1:0]  = wdata;
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (unmask_all) mask_d = 1'b0;
    if (clr_mask)   mask_d = 1'b0;
    if (set_mask)   mask_d = 1'b1;
    if (done)       mask_d = 1'b1;
    if (mask_all)   mask_d = 1'b1;
  end

  always_comb begin
    flag_d = flag_q;
    if (clr_flag) flag_d = 1'b0;
    if (done)     flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      page_q <= '0;
      type_q <= '0;
      mask_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      if (wr_page) page_q <= wdata;
      if (wr_mode) type_q <= wdata[3:2];
      mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign page     = page_q;
  assign xtype    = type_q;
  assign masked   = mask_q;
  assign flag     = flag_q;
endmodule

// File: rtl/dmac_prio.sv
module dmac_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] grant,
  input  logic         abort,
  input  logic         hold_ack,
  output logic         hold_req,
  output logic         xfer,
  output logic [N-1:0] sel
);
  sq_state_t    state_q, state_d;
  logic [N-1:0] sel_q;
  logic         sel_en;

  always_comb begin
    state_d = state_q;
    sel_en  = 1'b0;
    case (state_q)
      SQ_IDLE: if (|grant) begin
        state_d = SQ_HOLD;
        sel_en  = 1'b1;
      end
      SQ_HOLD: if (hold_ack) state_d = SQ_XFER;
      SQ_XFER: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
    if (abort) state_d = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      if (sel_en) sel_q <= grant;
    end
  end

  assign hold_req = (state_q != SQ_IDLE);
  assign xfer     = (state_q == SQ_XFER);
  assign sel      = sel_q;
endmodule

// File: rtl/dmac4_core.sv
module dmac4_core
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RW-1:0]    io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  input  logic [NCH-1:0]   dreq,
  output logic [NCH-1:0]   dack,
  output logic             hold_req,
  input  logic             hold_ack,
  output logic [PW+AW-1:0] mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             tc_pulse
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [2:0]      grp;
  logic [CH_W-1:0] csel;
  assign grp  = io_addr[RW-1:CH_W];
  assign csel = io_addr[CH_W-1:0];

  logic any_io, ptr_acc, clrbp_wr, mclr_wr, clrmask_wr, smask_wr, mode_wr, stat_rd;
  assign any_io     = io_wr || io_rd;
  assign ptr_acc    = any_io && (grp == GRP_ADDR || grp == GRP_CNT);
  assign clrbp_wr   = io_wr && (io_addr == RA_CLRBP);
  assign mclr_wr    = io_wr && (io_addr == RA_MCLR);
  assign clrmask_wr = io_wr && (io_addr == RA_CLRMASK);
  assign smask_wr   = io_wr && (io_addr == RA_SMASK);
  assign mode_wr    = io_wr && (io_addr == RA_MODE);
  assign stat_rd    = io_rd && (io_addr == RA_STAT);

  logic ptr_q, ptr_d;
  always_comb begin
    ptr_d = ptr_q;
    if (ptr_acc) ptr_d = ~ptr_q;
    if (clrbp_wr || mclr_wr) ptr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ptr_q <= 1'b0;
    else            ptr_q <= ptr_d;
  end

  logic [AW-1:0]  ch_addr [NCH];
  logic [AW-1:0]  ch_cnt  [NCH];
  logic [PW-1:0]  ch_page [NCH];
  logic [1:0]     ch_type [NCH];
  logic [NCH-1:0] ch_masked, ch_last, ch_flag, eligible, grant, sel, step;
  logic           xfer;

  assign eligible = dreq & ~ch_masked;

  dmac_prio #(.N(NCH)) u_prio (
    .req   (eligible),
    .grant (grant)
  );

  dmac_seq #(.N(NCH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .grant    (grant),
    .abort    (mclr_wr),
    .hold_ack (hold_ack),
    .hold_req (hold_req),
    .xfer     (xfer),
    .sel      (sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit     = (csel == CH_W'(c));
    assign step[c] = xfer && sel[c] && !mclr_wr;

    dmac_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .wr_addr    (io_wr && grp == GRP_ADDR && hit),
      .wr_cnt     (io_wr && grp == GRP_CNT && hit),
      .wr_page    (io_wr && grp == GRP_PAGE && hit),
      .wr_mode    (mode_wr && io_wdata[CH_W-1:0] == CH_W'(c)),
      .hi_sel     (ptr_q),
      .set_mask   (smask_wr && io_wdata[CH_W-1:0] == CH_W'(c) && io_wdata[2]),
      .clr_mask   (smask_wr && io_wdata[CH_W-1:0] == CH_W'(c) && !io_wdata[2]),
      .mask_all   (mclr_wr),
      .unmask_all (clrmask_wr),
      .clr_flag   (stat_rd || mclr_wr),
      .step       (step[c]),
      .wdata      (io_wdata),
      .cur_addr   (ch_addr[c]),
      .cur_cnt    (ch_cnt[c]),
      .page       (ch_page[c]),
      .xtype      (ch_type[c]),
      .masked     (ch_masked[c]),
      .last       (ch_last[c]),
      .flag       (ch_flag[c])
    );
  end

  logic [1:0] act_type;
  logic       act_last;

  always_comb begin
    mem_addr = '0;
    act_type = '0;
    act_last = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (sel[c]) begin
        mem_addr = mem_addr | {ch_page[c], ch_addr[c]};
        act_type = act_type | ch_type[c];
        act_last = act_last | ch_last[c];
      end
    end
    if (!xfer) mem_addr = '0;
  end

  assign dack     = xfer ? sel : '0;
  assign mem_wr   = xfer && (act_type == XT_TOMEM);
  assign mem_rd   = xfer && (act_type == XT_FROMMEM);
  assign tc_pulse = xfer && act_last;

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (io_addr == RA_STAT) begin
        io_rdata = {{(DW-NCH){1'b0}}, ch_flag};
      end else begin
        case (grp)
          GRP_ADDR: io_rdata = ptr_q ? ch_addr[csel][AW-1:DW] : ch_addr[csel][DW-1:0];
          GRP_CNT:  io_rdata = ptr_q ? ch_cnt[csel][AW-1:DW]  : ch_cnt[csel][DW-1:0];
          GRP_PAGE: io_rdata = ch_page[csel];
          default:  io_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmac4_core_chk.sv
module dmac4_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  dack,
  input logic        hold_req,
  input logic        hold_ack,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        tc_pulse
);
  // R10
  dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  // R10
  dack_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> hold_req);

  // R10
  dack_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> $past(hold_ack));

  // R10
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |=> !hold_req);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R5
  strobe_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (|dack));

  // R4
  tc_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (|dack));
endmodule

bind dmac4_core dmac4_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dack     (dack),
  .hold_req (hold_req),
  .hold_ack (hold_ack),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .tc_pulse (tc_pulse)
);

// File: tb/dmac4_core_test.sv
`timescale 1ns/1ps
module dmac4_core_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata;
  logic [3:0]  dreq, dack;
  logic        hold_req, hold_ack, ack_en;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr, tc_pulse;

  always #2.5 clk = ~clk;
  assign hold_ack = hold_req && ack_en;

  dmac4_core uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dreq(dreq), .dack(dack),
    .hold_req(hold_req), .hold_ack(hold_ack), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .tc_pulse(tc_pulse)
  );

  typedef struct {
    string       req;
    int          ch;
    logic [23:0] addr;
    logic        to_mem;
    logic        tc;
  } xfer_t;

  xfer_t exp_q[$];
  int total = 0, bad = 0, dack_count = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for every transfer the design performs
  always @(negedge clk) begin
    if (rst_n && |dack) begin
      dack_count++;
      if (exp_q.size() == 0) begin
        check("R6/R9 unexpected dack", {28'd0, dack}, 32'd0);
      end else begin
        xfer_t e;
        e = exp_q.pop_front();
        check({e.req, " dack"}, {28'd0, dack}, 32'd1 << e.ch);
        check({e.req, " R3 mem_addr"}, {8'd0, mem_addr}, {8'd0, e.addr});
        check({e.req, " R5 mem_wr"}, {31'd0, mem_wr}, {31'd0, e.to_mem});
        check({e.req, " R5 mem_rd"}, {31'd0, mem_rd}, {31'd0, !e.to_mem});
        check({e.req, " R4 tc_pulse"}, {31'd0, tc_pulse}, {31'd0, e.tc});
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [15:0] a, input logic [7:0] pg,
                      input int n, input logic [1:0] ty);
    logic [15:0] c;
    c = 16'(n - 1);
    wr(5'd14, 8'h00);
    wr(5'(ch), a[7:0]);
    wr(5'(ch), a[15:8]);
    wr(5'(4 + ch), c[7:0]);
    wr(5'(4 + ch), c[15:8]);
    wr(5'(8 + ch), pg);
    wr(5'd12, {2'b01, 2'b00, ty, 2'(ch)});
  endtask

  task automatic push(input string req, input int ch, input logic [15:0] a,
                      input logic [7:0] pg, input int n, input logic to_mem);
    for (int i = 0; i < n; i++) begin
      xfer_t e;
      e.req = req; e.ch = ch; e.to_mem = to_mem; e.tc = (i == n - 1);
      e.addr = {pg, 16'(a + 16'(i))};
      exp_q.push_back(e);
    end
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check({req, " scoreboard drained"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d, d2;
    int snap;
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    dreq = '0; ack_en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 hold_req", {31'd0, hold_req}, 0);
    check("R11 dack", {28'd0, dack}, 0);
    rd(5'd17, d);
    check("R11 status", {24'd0, d}, 0);
    snap = dack_count;
    dreq = 4'hF;
    repeat (20) @(negedge clk);
    check("R11 all masked", dack_count - snap, 0);
    dreq = 4'h0;

    // R2: pointer cleared between two low-byte writes
    wr(5'd14, 0); wr(5'd2, 8'h34); wr(5'd14, 0); wr(5'd2, 8'h78); wr(5'd2, 8'h56);
    wr(5'd14, 0); rd(5'd2, d); rd(5'd2, d2);
    check("R2 addr low after clear", {24'd0, d}, 32'h78);
    check("R2 addr high", {24'd0, d2}, 32'h56);
    // R1: count and address ports share one pointer
    wr(5'd14, 0); wr(5'd6, 8'hAA); wr(5'd2, 8'h99);
    wr(5'd14, 0); rd(5'd2, d); rd(5'd2, d2);
    check("R1 shared pointer low", {24'd0, d}, 32'h78);
    check("R1 shared pointer high", {24'd0, d2}, 32'h99);

    // R3/R4/R5: ch1 three transfers to memory across a 64K wrap
    prog(1, 16'hFFFE, 8'h12, 3, 2'b01);
    push("R3", 1, 16'hFFFE, 8'h12, 3, 1'b1);
    wr(5'd13, 8'h01);
    dreq[1] = 1'b1;
    drain("R4");
    snap = dack_count;
    repeat (20) @(negedge clk);
    check("R4 automask after tc", dack_count - snap, 0);
    dreq[1] = 1'b0;
    wr(5'd14, 0); rd(5'd1, d); rd(5'd1, d2);
    check("R3 address wrapped", {16'd0, d2, d}, 32'h0001);
    rd(5'd9, d);
    check("R3 page unchanged", {24'd0, d}, 32'h12);
    wr(5'd14, 0); rd(5'd5, d); rd(5'd5, d2);
    check("R4 count after tc", {16'd0, d2, d}, 32'hFFFF);
    rd(5'd17, d);
    check("R7 status flag ch1", {24'd0, d}, 32'h02);
    rd(5'd17, d);
    check("R7 status cleared by read", {24'd0, d}, 32'h00);

    // R9: ch0 beats ch2, ch3 requests but stays masked
    prog(2, 16'h0100, 8'h03, 2, 2'b10);
    prog(0, 16'h0200, 8'h00, 1, 2'b10);
    prog(3, 16'h0000, 8'h05, 1, 2'b01);
    push("R9", 0, 16'h0200, 8'h00, 1, 1'b0);
    push("R9", 2, 16'h0100, 8'h03, 2, 1'b0);
    wr(5'd13, 8'h00); wr(5'd13, 8'h02);
    dreq = 4'b1101;
    drain("R9");
    rd(5'd17, d);
    check("R9 status ch0 ch2", {24'd0, d}, 32'h05);

    // R6: unmask then mask ch3 again
    dreq = 4'b0000;
    wr(5'd13, 8'h03); wr(5'd13, 8'h07);
    snap = dack_count;
    dreq[3] = 1'b1;
    repeat (20) @(negedge clk);
    check("R6 masked channel idle", dack_count - snap, 0);
    // R8: clear-mask releases ch3
    push("R8", 3, 16'h0000, 8'h05, 1, 1'b1);
    wr(5'd16, 8'h00);
    drain("R8");
    dreq = 4'b0000;

    // R10: bus request held until grant
    prog(1, 16'h0010, 8'h40, 2, 2'b01);
    wr(5'd13, 8'h01);
    ack_en = 1'b0;
    snap = dack_count;
    dreq[1] = 1'b1;
    repeat (10) @(negedge clk);
    check("R10 hold_req waits", {31'd0, hold_req}, 1);
    check("R10 no dack before grant", dack_count - snap, 0);
    push("R10", 1, 16'h0010, 8'h40, 2, 1'b1);
    ack_en = 1'b1;
    drain("R10");
    check("R10 bus released", {31'd0, hold_req}, 0);
    dreq = 4'b0000;

    // R8: master clear resets pointer, flags and masks
    wr(5'd14, 0); wr(5'd0, 8'h11); wr(5'd0, 8'h33); wr(5'd0, 8'h44);
    wr(5'd15, 0);
    wr(5'd0, 8'h22);
    wr(5'd14, 0); rd(5'd0, d); rd(5'd0, d2);
    check("R8 pointer reset low", {24'd0, d}, 32'h22);
    check("R8 high untouched", {24'd0, d2}, 32'h33);
    rd(5'd17, d);
    check("R8 status cleared", {24'd0, d}, 0);
    snap = dack_count;
    dreq = 4'hF;
    repeat (20) @(negedge clk);
    check("R8 all masked", dack_count - snap, 0);
    dreq = 4'h0;

    finish_run();
  end
endmodule